// File: doc/BRIEF.md
# SPI Flash Command and DMA Engine

This block lets software run one SPI flash transaction at a time by filling a small set of memory-mapped registers. The registers hold up to five command bytes, a mask that says which command byte positions carry data, a count of bytes to clock in, a count of bytes to program, and a local memory address. Software then writes the command-count register with its start bit set.

The engine lowers chip select and shifts the command bytes out most significant bit first, in SPI mode 0. It then streams program bytes that it fetches from local memory, clocks in read bytes and stores them to local memory, or stops. A command with neither program nor read bytes is a bare instruction, such as a write-enable. After the last bit, chip select rises and stays high for a short gap. Only then does the done register read 1, and software polls that register.

Local memory is reached through a simple word-wide request/ready master. Read bytes are packed into little-endian words and written with byte enables, so start addresses and lengths need not be word aligned.

Top module: `spi_flash_dma`

## Requirements
- R1: Registers, decoded from the low 6 address bits, are: divider 0x00 (bits DIV_W-1:0), command count 0x04 (bits 6:0 byte count, bit 7 start, bits 27:8 program length), read count 0x08 (bits RDCNT_W-1:0), command word A 0x0C, command word B 0x10, direction mask 0x14 (bits 4:0), done 0x18 (bit 0, read-only) and memory address 0x1C. Every register reads back what was stored, the start bit reads 0, and unmapped offsets read 0.
- R2: Command bytes are sent in this order: A[7:0], A[15:8], A[23:16], A[31:24], B[7:0]. Each byte goes out most significant bit first. A count above 5 sends 5 bytes.
- R3: Direction mask bit i governs command byte i. When the bit is 1 the byte is driven on MOSI. When the bit is 0 the byte position is still clocked, but MOSI is held at 0.
- R4: SCLK idles low. MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. The SCLK period is 2×divider system clocks, and a divider of 0 acts as 1. MOSI is 0 during read bytes.
- R5: Chip select stays low from before the first SCLK rise until after the last SCLK fall. A transfer gives exactly 8×(command + program + read) SCLK pulses, and SCLK is never high while chip select is high.
- R6: Program bytes follow the command bytes. They are taken from local memory at ascending byte addresses, starting at the address register, and any alignment is allowed. A memory request holds its address until ready.
- R7: Read bytes come after any program bytes. They are stored at ascending byte addresses that continue from where the program bytes ended. They are packed little-endian (address bits 1:0 select the lane), and only stored lanes are enabled. No other memory byte changes.
- R8: When the read count and the program length are both 0, only the command bytes are sent and local memory is not accessed.
- R9: A write that starts a transfer clears done on the next cycle. Done reads 1 only after chip select has been high for at least 2 system clocks following the transfer.
- R10: A start written while a transfer is running is ignored. Register writes made during a transfer do not change the bytes of that transfer.
- R11: After reset, chip select is high, SCLK and MOSI are low, no memory request is made, and all registers, including done, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr (combinational) |
| spiSclk | output | 1 | SPI serial clock |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Word-aligned byte address |
| memWdata | output | 32 | Write data |
| memStrb | output | 4 | Byte enables for writes |
| memRdata | input | 32 | Read data, valid while memReady is high |
| memReady | input | 1 | Request accepted this cycle |

## Verification
Two events can fall in the same cycle: a register write or a fresh start from software, and the engine's own progress through a running transfer. In the collision case, the command word, the direction mask and the start bit are rewritten part-way through the command phase. The serial bytes captured by the bench flash model must still match the first request, and the pulse count must cover only that request. The memory ready line stalls on a fixed rhythm, so fetches and write-backs also land on the same cycles in which serial bytes complete. Those cases are judged by comparing the whole memory image and the program bytes seen on MOSI.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  localparam logic [5:0] OFF_DIV   = 6'h00;
  localparam logic [5:0] OFF_CMD   = 6'h04;
  localparam logic [5:0] OFF_RDCNT = 6'h08;
  localparam logic [5:0] OFF_BUFA  = 6'h0C;
  localparam logic [5:0] OFF_BUFB  = 6'h10;
  localparam logic [5:0] OFF_DIR   = 6'h14;
  localparam logic [5:0] OFF_DONE  = 6'h18;
  localparam logic [5:0] OFF_ADDR  = 6'h1C;

  localparam int MaxCmdBytes = 5;
  localparam int ProgLenW    = 20;

  typedef struct packed {
    logic       shiftStart;
    logic [7:0] shiftData;
    logic       packByte;
    logic [1:0] packLane;
    logic       packClear;
  } dpCtl_t;

  typedef enum logic [3:0] {
    stIdle, stCmd, stCmdWait, stFetch, stProgWait,
    stRdStart, stRdWait, stWrite, stEnd, stGap
  } engState_t;

endpackage

// File: rtl/spi_dma_dp.sv
module spi_dma_dp
  import spi_dma_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  input  dpCtl_t           ctl,
  input  logic             spiMiso,
  output logic             byteDone,
  output logic             spiSclk,
  output logic             spiMosi,
  output logic [31:0]      packWord,
  output logic [3:0]       packStrb
);

  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] divCnt;
  logic [7:0]       txSh;
  logic [7:0]       rxSh;
  logic [2:0]       bitCnt;
  logic             busy;

  always_comb divEff = (divIn == '0) ? DIV_W'(1) : divIn;

  // bit engine: half period of divEff clocks, sample on rise, shift on fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      spiSclk  <= 1'b0;
      spiMosi  <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
      bitCnt   <= '0;
      divCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (ctl.shiftStart) begin
        busy    <= 1'b1;
        txSh    <= ctl.shiftData;
        spiMosi <= ctl.shiftData[7];
        spiSclk <= 1'b0;
        bitCnt  <= '0;
        divCnt  <= '0;
      end else if (busy) begin
        if (divCnt == divEff - DIV_W'(1)) begin
          divCnt <= '0;
          if (!spiSclk) begin
            spiSclk <= 1'b1;
            rxSh    <= {rxSh[6:0], spiMiso};
          end else begin
            spiSclk <= 1'b0;
            if (bitCnt == 3'd7) begin
              busy     <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txSh    <= {txSh[6:0], 1'b0};
              spiMosi <= txSh[6];
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  // little-endian packer for received bytes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packWord <= '0;
      packStrb <= '0;
    end else if (ctl.packClear) begin
      packStrb <= '0;
    end else if (ctl.packByte) begin
      packWord[8*ctl.packLane +: 8] <= rxSh;
      packStrb[ctl.packLane]        <= 1'b1;
    end
  end

  p_mosi_low_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiMosi) |-> !spiSclk)
    else $error("MOSI moved while SCLK high");

  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(spiSclk) |-> $past(busy))
    else $error("SCLK toggled outside a byte");

endmodule

// File: rtl/spi_dma_ctrl.sv
module spi_dma_ctrl
  import spi_dma_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int RDCNT_W = 16,
  parameter int CS_GAP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic [DIV_W-1:0]  divOut,
  output dpCtl_t            ctl,
  input  logic              byteDone,
  input  logic [31:0]       packWord,
  input  logic [3:0]        packStrb,
  output logic              spiCsN,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memStrb,
  input  logic [31:0]       memRdata,
  input  logic              memReady
);

  localparam int CmdShW = 8 * MaxCmdBytes;
  localparam int GapW   = $clog2(CS_GAP + 1);

  logic [DIV_W-1:0]       divReg;
  logic [6:0]             cmdCntReg;
  logic [ProgLenW-1:0]    progReg;
  logic [RDCNT_W-1:0]     rdCntReg;
  logic [31:0]            bufA, bufB;
  logic [MaxCmdBytes-1:0] dirReg;
  logic [ADDR_W-1:0]      addrReg;
  logic                   doneR;

  engState_t              st;
  logic [CmdShW-1:0]      cmdSh;
  logic [2:0]             cmdLeft;
  logic [ProgLenW-1:0]    progLeft;
  logic [RDCNT_W-1:0]     rdLeft;
  logic [ADDR_W-1:0]      curAddr, wbAddr;
  logic [GapW-1:0]        gapCnt;

  logic              busy, startReq, startAcc;
  logic [CmdShW-1:0] srcCmd, maskedCmd;
  logic [2:0]        reqCnt;

  assign busy     = (st != stIdle);
  assign startReq = regWr && (regAddr == OFF_CMD) && regWdata[7];
  assign startAcc = startReq && !busy;
  assign srcCmd   = {bufB[7:0], bufA};
  assign reqCnt   = (regWdata[6:0] > 7'(MaxCmdBytes)) ? 3'(MaxCmdBytes) : regWdata[2:0];
  assign divOut   = divReg;

  for (genvar i = 0; i < MaxCmdBytes; i++) begin : g_cmdByte
    assign maskedCmd[8*i +: 8] = dirReg[i] ? srcCmd[8*i +: 8] : 8'h00;
  end

  function automatic engState_t nextPhase(input logic [ProgLenW-1:0] p,
                                          input logic [RDCNT_W-1:0] r);
    if (p != '0)      return stFetch;
    else if (r != '0) return stRdStart;
    else              return stEnd;
  endfunction

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg    <= '0;
      cmdCntReg <= '0;
      progReg   <= '0;
      rdCntReg  <= '0;
      bufA      <= '0;
      bufB      <= '0;
      dirReg    <= '0;
      addrReg   <= '0;
    end else if (regWr) begin
      unique case (regAddr)
        OFF_DIV:   divReg   <= regWdata[DIV_W-1:0];
        OFF_CMD: begin
          cmdCntReg <= regWdata[6:0];
          progReg   <= regWdata[8 +: ProgLenW];
        end
        OFF_RDCNT: rdCntReg <= regWdata[RDCNT_W-1:0];
        OFF_BUFA:  bufA     <= regWdata;
        OFF_BUFB:  bufB     <= regWdata;
        OFF_DIR:   dirReg   <= regWdata[MaxCmdBytes-1:0];
        OFF_ADDR:  addrReg  <= regWdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_DIV:   regRdata = 32'(divReg);
      OFF_CMD:   regRdata = {4'b0, progReg, 1'b0, cmdCntReg};
      OFF_RDCNT: regRdata = 32'(rdCntReg);
      OFF_BUFA:  regRdata = bufA;
      OFF_BUFB:  regRdata = bufB;
      OFF_DIR:   regRdata = 32'(dirReg);
      OFF_DONE:  regRdata = {31'b0, doneR};
      OFF_ADDR:  regRdata = 32'(addrReg);
      default:   regRdata = '0;
    endcase
  end

  // transaction sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= stIdle;
      cmdSh    <= '0;
      cmdLeft  <= '0;
      progLeft <= '0;
      rdLeft   <= '0;
      curAddr  <= '0;
      wbAddr   <= '0;
      gapCnt   <= '0;
      doneR    <= 1'b0;
      spiCsN   <= 1'b1;
    end else begin
      unique case (st)
        stIdle: if (startAcc) begin
          cmdSh    <= maskedCmd;
          cmdLeft  <= reqCnt;
          progLeft <= regWdata[8 +: ProgLenW];
          rdLeft   <= rdCntReg;
          curAddr  <= addrReg;
          doneR    <= 1'b0;
          spiCsN   <= 1'b0;
          st       <= stCmd;
        end
        stCmd: st <= (cmdLeft == '0) ? nextPhase(progLeft, rdLeft) : stCmdWait;
        stCmdWait: if (byteDone) begin
          cmdSh   <= cmdSh >> 8;
          cmdLeft <= cmdLeft - 3'd1;
          st      <= stCmd;
        end
        stFetch: if (memReady) st <= stProgWait;
        stProgWait: if (byteDone) begin
          curAddr  <= curAddr + ADDR_W'(1);
          progLeft <= progLeft - ProgLenW'(1);
          st       <= nextPhase(progLeft - ProgLenW'(1), rdLeft);
        end
        stRdStart: st <= stRdWait;
        stRdWait: if (byteDone) begin
          curAddr <= curAddr + ADDR_W'(1);
          rdLeft  <= rdLeft - RDCNT_W'(1);
          wbAddr  <= {curAddr[ADDR_W-1:2], 2'b00};
          st      <= (curAddr[1:0] == 2'd3 || rdLeft == RDCNT_W'(1)) ? stWrite : stRdStart;
        end
        stWrite: if (memReady) st <= (rdLeft == '0) ? stEnd : stRdStart;
        stEnd: begin
          spiCsN <= 1'b1;
          gapCnt <= '0;
          st     <= stGap;
        end
        stGap: begin
          if (gapCnt == GapW'(CS_GAP - 1)) begin
            doneR <= 1'b1;
            st    <= stIdle;
          end else begin
            gapCnt <= gapCnt + GapW'(1);
          end
        end
        default: st <= stIdle;
      endcase
    end
  end

  always_comb begin
    ctl.shiftStart = ((st == stCmd) && (cmdLeft != '0)) ||
                     ((st == stFetch) && memReady) || (st == stRdStart);
    if (st == stCmd)        ctl.shiftData = cmdSh[7:0];
    else if (st == stFetch) ctl.shiftData = memRdata[8*curAddr[1:0] +: 8];
    else                    ctl.shiftData = 8'h00;
    ctl.packByte  = (st == stRdWait) && byteDone;
    ctl.packLane  = curAddr[1:0];
    ctl.packClear = (st == stWrite) && memReady;
  end

  assign memValid = (st == stFetch) || (st == stWrite);
  assign memWrite = (st == stWrite);
  assign memAddr  = (st == stWrite) ? wbAddr : {curAddr[ADDR_W-1:2], 2'b00};
  assign memWdata = packWord;
  assign memStrb  = (st == stWrite) ? packStrb : 4'b0000;

  p_start_clears_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    startAcc |=> !doneR)
    else $error("done not cleared by start");

  p_gap_before_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneR) |-> spiCsN && $past(spiCsN) && $past(spiCsN, 2))
    else $error("done raised without chip-select gap");

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && busy) |=> cmdLeft <= $past(cmdLeft))
    else $error("start accepted while busy");

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> memValid && $stable(memAddr) && $stable(memWrite))
    else $error("memory request dropped or changed before ready");

  p_write_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite) |-> (memStrb != 4'b0000))
    else $error("memory write with no byte enabled");

endmodule

// File: rtl/spi_flash_dma.sv
module spi_flash_dma
  import spi_dma_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int RDCNT_W = 16,
  parameter int CS_GAP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [5:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memStrb,
  input  logic [31:0]       memRdata,
  input  logic              memReady
);

  dpCtl_t           ctl;
  logic [DIV_W-1:0] divVal;
  logic             byteDone;
  logic [31:0]      packWord;
  logic [3:0]       packStrb;

  spi_dma_ctrl #(
    .DIV_W(DIV_W), .ADDR_W(ADDR_W), .RDCNT_W(RDCNT_W), .CS_GAP(CS_GAP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .divOut(divVal), .ctl(ctl), .byteDone(byteDone),
    .packWord(packWord), .packStrb(packStrb),
    .spiCsN(spiCsN),
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memStrb(memStrb), .memRdata(memRdata), .memReady(memReady)
  );

  spi_dma_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .divIn(divVal), .ctl(ctl), .spiMiso(spiMiso),
    .byteDone(byteDone), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .packWord(packWord), .packStrb(packStrb)
  );

  p_sclk_in_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsN)
    else $error("SCLK high with chip select released");

endmodule

// File: tb/sim_spi_flash_dma.sv
module sim_spi_flash_dma;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [5:0]  regAddr = 6'h18;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        spiSclk, spiCsN, spiMosi, spiMiso;
  logic        memValid, memWrite, memReady;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memStrb;

  always #(ClkPeriod/2) clk = ~clk;

  spi_flash_dma u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memStrb(memStrb), .memRdata(memRdata), .memReady(memReady)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] initByte(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction
  function automatic logic [7:0] patByte(input int n);
    return 8'(n * 37 + 5);
  endfunction

  // local memory model with a fixed stall rhythm
  logic [31:0] mem [0:63];
  logic fillReq = 1'b0;
  int rdyCnt = 0;
  always @(posedge clk) rdyCnt <= rdyCnt + 1;
  assign memReady = (rdyCnt % 3) != 2;
  assign memRdata = mem[memAddr[7:2]];
  always @(posedge clk) begin
    if (fillReq) begin
      for (int w = 0; w < 64; w++)
        mem[w] <= {initByte(4*w+3), initByte(4*w+2), initByte(4*w+1), initByte(4*w)};
    end else if (memValid && memWrite && memReady) begin
      for (int b = 0; b < 4; b++)
        if (memStrb[b]) mem[memAddr[7:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end
  end

  // flash model and link monitor, sampled away from the active edge
  int bitCnt = 0, memAcc = 0, perErr = 0, stabErr = 0, lastRise = 0, csRiseCyc = 0;
  int expDiv = 1;
  logic sclkPrev = 1'b0, csPrev = 1'b1, mosiAtRise = 1'b0;
  logic [7:0] shiftIn = '0;
  logic [7:0] txLog [0:31];

  function automatic logic misoBit(input int bc);
    logic [7:0] p;
    p = patByte(bc / 8);
    return p[7 - (bc % 8)];
  endfunction
  assign spiMiso = misoBit(bitCnt);

  always @(negedge clk) begin
    sclkPrev <= spiSclk;
    csPrev   <= spiCsN;
    if (!spiCsN && csPrev) begin
      bitCnt <= 0; memAcc <= 0; perErr <= 0; stabErr <= 0; lastRise <= cyc;
    end else begin
      if (spiCsN && !csPrev) csRiseCyc <= cyc;
      if (spiSclk && !sclkPrev) begin
        shiftIn <= {shiftIn[6:0], spiMosi};
        if ((bitCnt % 8) == 7 && (bitCnt / 8) < 32) txLog[bitCnt / 8] <= {shiftIn[6:0], spiMosi};
        if ((bitCnt % 8) != 0 && (cyc - lastRise) != 2 * expDiv) perErr <= perErr + 1;
        lastRise   <= cyc;
        mosiAtRise <= spiMosi;
        bitCnt     <= bitCnt + 1;
      end else if (spiSclk && spiMosi != mosiAtRise) begin
        stabErr <= stabErr + 1;
      end
      if (memValid && memReady) memAcc <= memAcc + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 6'h18;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
    regAddr = 6'h18;
  endtask

  int eN, eProg, eRd, eAddr;
  logic [4:0]  eDir;
  logic [31:0] eB1, eB2;

  task automatic startXfer(input int n, input logic [4:0] dir, input logic [31:0] b1,
                           input logic [31:0] b2, input int prog, input int rd,
                           input int addr, input int div);
    eN = n; eDir = dir; eB1 = b1; eB2 = b2; eProg = prog; eRd = rd; eAddr = addr;
    expDiv = (div == 0) ? 1 : div;
    @(negedge clk) fillReq = 1'b1;
    @(negedge clk) fillReq = 1'b0;
    regWrite(6'h00, 32'(div));
    regWrite(6'h0C, b1);
    regWrite(6'h10, b2);
    regWrite(6'h14, 32'(dir));
    regWrite(6'h1C, 32'(addr));
    regWrite(6'h08, 32'(rd));
    regWrite(6'h04, {4'b0, 20'(prog), 1'b1, 7'(n)});
    #1 chk(regRdata[0] == 1'b0, "R9 done cleared by start", 32'(regRdata[0]), 32'd0);
  endtask

  task automatic finishXfer();
    int effN, total, doneCyc, bad, firstA;
    logic [7:0] srcB, expB, actB, firstE, firstG;
    logic seen;
    seen = 1'b0; doneCyc = 0;
    for (int t = 0; t < 20000 && !seen; t++) begin
      @(negedge clk);
      if (regRdata[0]) begin seen = 1'b1; doneCyc = cyc; end
    end
    chk(seen, "R9 done within time limit", 32'(seen), 32'd1);
    effN  = (eN > 5) ? 5 : eN;
    total = effN + eProg + eRd;
    chk(bitCnt == 8 * total, "R5 SCLK pulse count", 32'(bitCnt), 32'(8 * total));
    chk(spiCsN == 1'b1, "R5 chip select released", 32'(spiCsN), 32'd1);
    chk(doneCyc - csRiseCyc >= 2, "R9 chip-select gap before done",
        32'(doneCyc - csRiseCyc), 32'd2);
    chk(perErr == 0 && stabErr == 0, "R4 SCLK period and MOSI stability",
        32'(perErr + stabErr), 32'd0);
    // command bytes: R2 ordering, R3 direction masking
    bad = 0; firstE = 0; firstG = 0;
    for (int i = 0; i < effN; i++) begin
      srcB = (i < 4) ? eB1[8*i +: 8] : eB2[7:0];
      expB = eDir[i] ? srcB : 8'h00;
      if (txLog[i] != expB) begin
        if (bad == 0) begin firstE = expB; firstG = txLog[i]; end
        bad++;
      end
    end
    chk(bad == 0, "R2 R3 command bytes on MOSI", 32'(firstG), 32'(firstE));
    // R6 program bytes
    bad = 0;
    for (int j = 0; j < eProg; j++) begin
      expB = initByte(eAddr + j);
      if (txLog[effN + j] != expB) begin
        if (bad == 0) begin firstE = expB; firstG = txLog[effN + j]; end
        bad++;
      end
    end
    if (eProg > 0) chk(bad == 0, "R6 program bytes on MOSI", 32'(firstG), 32'(firstE));
    // R4 MOSI low in read phase
    bad = 0;
    for (int j = 0; j < eRd; j++) if (txLog[effN + eProg + j] != 8'h00) bad++;
    if (eRd > 0) chk(bad == 0, "R4 MOSI low during read bytes", 32'(bad), 32'd0);
    // R7 whole memory image
    bad = 0; firstA = 0;
    for (int a = 0; a < 256; a++) begin
      int rel;
      rel  = a - eAddr - eProg;
      expB = (rel >= 0 && rel < eRd) ? patByte(effN + eProg + rel) : initByte(a);
      actB = mem[a / 4][8*(a % 4) +: 8];
      if (actB != expB) begin
        if (bad == 0) begin firstA = a; firstE = expB; firstG = actB; end
        bad++;
      end
    end
    chk(bad == 0, $sformatf("R7 memory image (first bad byte %0d)", firstA),
        32'(firstG), 32'(firstE));
    if (eProg == 0 && eRd == 0)
      chk(memAcc == 0, "R8 no memory access for command-only", 32'(memAcc), 32'd0);
  endtask

  bit finished = 1'b0;

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R11 reset state
    #1;
    chk(spiCsN == 1'b1, "R11 chip select after reset", 32'(spiCsN), 32'd1);
    chk(spiSclk == 1'b0 && spiMosi == 1'b0, "R11 SCLK/MOSI after reset",
        {30'b0, spiSclk, spiMosi}, 32'd0);
    chk(memValid == 1'b0, "R11 no memory request after reset", 32'(memValid), 32'd0);
    for (int a = 0; a < 64; a += 4) begin
      regRead(6'(a), d);
      chk(d == 32'd0, $sformatf("R11 register %0h reads 0 after reset", a), d, 32'd0);
    end

    // R1 register map and readback
    regWrite(6'h00, 32'h0000_1234); regRead(6'h00, d);
    chk(d == 32'h34, "R1 divider readback", d, 32'h34);
    regWrite(6'h04, 32'hF123_4567); regRead(6'h04, d);
    chk(d == 32'h0123_4567, "R1 command count readback", d, 32'h0123_4567);
    regWrite(6'h08, 32'h000A_BCDE); regRead(6'h08, d);
    chk(d == 32'h0000_BCDE, "R1 read count readback", d, 32'h0000_BCDE);
    regWrite(6'h0C, 32'hDEAD_BEEF); regRead(6'h0C, d);
    chk(d == 32'hDEAD_BEEF, "R1 command word A readback", d, 32'hDEAD_BEEF);
    regWrite(6'h10, 32'hCAFE_F00D); regRead(6'h10, d);
    chk(d == 32'hCAFE_F00D, "R1 command word B readback", d, 32'hCAFE_F00D);
    regWrite(6'h14, 32'hFFFF_FFFF); regRead(6'h14, d);
    chk(d == 32'h1F, "R1 direction mask readback", d, 32'h1F);
    regWrite(6'h1C, 32'h0000_0ABC); regRead(6'h1C, d);
    chk(d == 32'h0ABC, "R1 address readback", d, 32'h0ABC);
    regWrite(6'h18, 32'h1); regRead(6'h18, d);
    chk(d == 32'h0, "R1 done is read-only", d, 32'h0);
    regRead(6'h20, d);
    chk(d == 32'h0, "R1 unmapped offset reads 0", d, 32'h0);

    // R2 R8 command-only, every count including a clamped one
    for (int n = 1; n <= 7; n++) begin
      startXfer(n, 5'h1F, 32'h0403_0201 + 32'(n), 32'h0000_00A5, 0, 0, 8'h40, 1);
      finishXfer();
    end

    // R3 every direction mask on a five-byte command
    for (int m = 0; m < 32; m++) begin
      startXfer(5, 5'(m), 32'h9F3C_0BE7, 32'h0000_0081, 0, 0, 8'h40, 1);
      finishXfer();
    end

    // R7 read lengths across all start alignments
    for (int off = 0; off < 4; off++)
      for (int rd = 1; rd <= 9; rd++) begin
        startXfer(1, 5'h01, 32'h0000_0003, 32'h0, 0, rd, 8'h40 + off, 1);
        finishXfer();
      end

    // R6 program lengths across all start alignments
    for (int off = 0; off < 4; off++)
      for (int pg = 1; pg <= 9; pg++) begin
        startXfer(4, 5'h0F, 32'h3412_0002, 32'h0, pg, 0, 8'h60 + off, 1);
        finishXfer();
      end

    // R6 R7 program then read in one frame
    startXfer(5, 5'h1F, 32'h0011_220B, 32'h0000_00A5, 3, 5, 8'h52, 2);
    finishXfer();

    // R4 divider variants including zero
    for (int dv = 0; dv <= 5; dv++) begin
      startXfer(2, 5'h03, 32'h0000_9F05, 32'h0, 0, 3, 8'h81, dv);
      finishXfer();
    end

    // R10 rewrite and restart while a transfer is in flight
    startXfer(3, 5'h07, 32'h00C0_FFEE, 32'h0, 0, 2, 8'h90, 1);
    repeat (20) @(negedge clk);
    regWrite(6'h0C, 32'h1122_3344);
    regWrite(6'h14, 32'h0);
    regWrite(6'h04, {4'b0, 20'd0, 1'b1, 7'd5});
    finishXfer();
    regRead(6'h0C, d);
    chk(d == 32'h1122_3344, "R10 register write during transfer stored", d, 32'h1122_3344);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R9 act=running exp=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule